// File: doc/BRIEF.md
# Write-Once Configured Watchdog Timer

This block is a watchdog that asks for a system reset when software stops servicing it. It counts rising edges of a slow reference tick of about 1 kHz. That tick is asynchronous to the bus clock, so the block synchronises it into a single-cycle enable. Software picks one of two timeouts: a short one of 32 ticks or a long one of 256 ticks. The watchdog runs from reset with the long timeout selected, so a system that never configures it is still protected.

Software reaches the block through a small register port with two addresses. The options address holds the enable and timeout-select bits. It takes only the first write after reset; that write also restarts the count, and the setting then stays fixed until the next reset. The status address is read-only and shows the sticky timeout flag. Any write to the status address is used only as a service event and restarts the count. A debug input freezes the count. A low-power stop input holds the count at zero, so counting starts again from zero when stop ends. On expiry the block sends a one-cycle reset request and sets the flag.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the options read back at address 0 as bit 0 = enable = 1 and bit 1 = long select = 1, other bits 0. The status at address 1 reads 0, the count is zero and no reset request is raised.
- R2: With bit 1 = 0 a request follows the 32nd counted tick after the last counter clear; with bit 1 = 1 it follows the 256th.
- R3: Each rising edge of the reference tick advances the count by one, however long the tick stays high.
- R4: A write of any data to address 1 clears the count and leaves the status contents unchanged.
- R5: Only the first write to address 0 after reset is accepted. Later writes change neither the option bits nor the count.
- R6: The accepted first write to address 0 clears the count.
- R7: With enable = 0 the count does not advance and no request is raised.
- R8: While the debug freeze input is high the count holds its value.
- R9: While the stop input is high the count is zero and does not advance; after stop falls it counts up from zero.
- R10: On expiry the reset request is high for exactly one clock, status bit 0 at address 1 becomes 1 and stays set until reset, and the count restarts from zero.
- R11: When a counter clear and a tick edge take effect in the same clock, the clear wins: the count ends at zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| refTick | input | 1 | Asynchronous slow reference tick (about 1 kHz) |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address (0 options, 1 status) |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| dbgFreeze | input | 1 | Debug mode, holds the count |
| stopMode | input | 1 | Low-power stop, holds the count at zero |
| rstReq | output | 1 | One-cycle system reset request |
| wdFlag | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
A synchronised tick edge and a counter clear can land on the same clock. The clear may come from a service write, from the first options write or from stop. The bench provokes this by holding a service write across the clock on which the synchronised tick takes effect. It judges the outcome by expiry timing: the reference model puts the count at zero, so the next request must come only after a full timeout period, and no request may appear on the colliding tick.

// File: rtl/svc_watchdog_pkg.sv
package svc_watchdog_pkg;

  // Strobes from the control to the counting datapath
  typedef struct packed {
    logic cntClr;   // clear the count (priority over stepping)
    logic cntStep;  // one qualified reference tick this cycle
    logic longSel;  // 1: long timeout, 0: short timeout
  } wd_strobe_t;

endpackage

// File: rtl/svc_watchdog_tick_sync.sv
module svc_watchdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickAsync,
  output logic tickPulse
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= tickAsync;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[STAGES-1];
  end

  assign tickPulse = syncQ[STAGES-1] & ~prevQ;

endmodule

// File: rtl/svc_watchdog_ctrl.sv
module svc_watchdog_ctrl
  import svc_watchdog_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int OPT_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              tickPulse,
  input  logic              dbgFreeze,
  input  logic              stopMode,
  input  logic              wdFlag,
  output wd_strobe_t        strb,
  output logic [DATA_W-1:0] busRdData,
  output logic              optEn,
  output logic              optLong,
  output logic              optLocked
);

  localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic optHit, svcHit, firstWr;

  assign optHit  = busWrEn && (busAddr == OPT_A);
  assign svcHit  = busWrEn && (busAddr == STAT_A);
  assign firstWr = optHit && !optLocked;

  // Write-once options: defaults enabled, long timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optEn     <= 1'b1;
      optLong   <= 1'b1;
      optLocked <= 1'b0;
    end else if (firstWr) begin
      optEn     <= busWrData[0];
      optLong   <= busWrData[1];
      optLocked <= 1'b1;
    end
  end

  always_comb begin
    strb.cntClr  = svcHit | firstWr | stopMode;
    strb.cntStep = tickPulse & optEn & ~dbgFreeze;
    strb.longSel = optLong;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == OPT_A) begin
      busRdData[0] = optEn;
      busRdData[1] = optLong;
    end else if (busAddr == STAT_A) begin
      busRdData[0] = wdFlag;
    end
  end

endmodule

// File: rtl/svc_watchdog_dp.sv
module svc_watchdog_dp
  import svc_watchdog_pkg::*;
#(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 8,
  localparam int CNT_W     = LONG_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wd_strobe_t       strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             rstReq,
  output logic             wdFlag
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_LOG2) - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((1 << LONG_LOG2) - 1);

  logic [CNT_W-1:0] lastVal;
  logic             atLast, expire;

  assign lastVal = strb.longSel ? LONG_LAST : SHORT_LAST;
  assign atLast  = (cntVal >= lastVal);
  assign expire  = strb.cntStep && !strb.cntClr && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (strb.cntClr)  cntVal <= '0;
    else if (strb.cntStep) cntVal <= atLast ? '0 : cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq <= 1'b0;
      wdFlag <= 1'b0;
    end else begin
      rstReq <= expire;
      wdFlag <= wdFlag | expire;
    end
  end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_watchdog_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int OPT_ADDR    = 0,
  parameter int STAT_ADDR   = 1,
  parameter int SHORT_LOG2  = 5,
  parameter int LONG_LOG2   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              dbgFreeze,
  input  logic              stopMode,
  output logic              rstReq,
  output logic              wdFlag
);

  wd_strobe_t           strb;
  logic                 tickPulse;
  logic                 optEn, optLong, optLocked;
  logic [LONG_LOG2-1:0] cntVal;

  svc_watchdog_tick_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .tickAsync(refTick), .tickPulse(tickPulse)
  );

  svc_watchdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_ADDR(OPT_ADDR), .STAT_ADDR(STAT_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .tickPulse(tickPulse), .dbgFreeze(dbgFreeze),
    .stopMode(stopMode), .wdFlag(wdFlag), .strb(strb), .busRdData(busRdData),
    .optEn(optEn), .optLong(optLong), .optLocked(optLocked)
  );

  svc_watchdog_dp #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal),
    .rstReq(rstReq), .wdFlag(wdFlag)
  );

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int CNT_W      = 8,
  parameter int SHORT_LOG2 = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             rstReq,
  input logic             wdFlag,
  input logic             optEn,
  input logic             optLong,
  input logic             optLocked,
  input logic [CNT_W-1:0] cnt,
  input logic             cntClr,
  input logic             dbgFreeze,
  input logic             stopMode
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_LOG2) - 1);

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdFlag |=> wdFlag);
  a_r10_req_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> wdFlag);
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !optEn |=> !rstReq);
  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dbgFreeze && !cntClr) |=> $stable(cnt));
  a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> (cnt == '0));
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> ((cnt == '0) && !rstReq));
  a_r5_lock_stable: assert property (@(posedge clk) disable iff (!rstN)
    optLocked |=> (optLocked && $stable(optEn) && $stable(optLong)));
  a_r2_short_bound: assert property (@(posedge clk) disable iff (!rstN)
    !optLong |-> (cnt <= SHORT_LAST));

endmodule

bind svc_watchdog svc_watchdog_chk #(.CNT_W(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) chk_i (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .wdFlag(wdFlag),
  .optEn(optEn), .optLong(optLong), .optLocked(optLocked),
  .cnt(cntVal), .cntClr(strb.cntClr), .dbgFreeze(dbgFreeze), .stopMode(stopMode)
);

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       dbgFreeze = 1'b0;
  logic       stopMode = 1'b0;
  logic       rstReq, wdFlag;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  // reference model state
  int mCnt;
  bit mEn, mLong, mLock, mFlag, mDbg, mStop;

  always #2.5 clk = ~clk;

  svc_watchdog dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .dbgFreeze(dbgFreeze), .stopMode(stopMode), .rstReq(rstReq), .wdFlag(wdFlag)
  );

  function automatic int lastOf(bit lng);
    return lng ? 255 : 31;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; busWrEn = 1'b0; refTick = 1'b0;
    dbgFreeze = 1'b0; stopMode = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mEn = 1; mLong = 1; mLock = 0; mFlag = 0; mDbg = 0; mStop = 0;
    @(negedge clk);
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic writeSvc(logic [7:0] d);
    busWrite(2'd1, d);
    mCnt = 0;
  endtask

  task automatic writeOpt(logic [7:0] d);
    busWrite(2'd0, d);
    if (!mLock) begin
      mEn = d[0]; mLong = d[1]; mLock = 1; mCnt = 0;
    end
  endtask

  task automatic readChk(string optTag, string statTag);
    busAddr = 2'd0; #1;
    chk(optTag, busRdData, {6'd0, mLong, mEn});
    busAddr = 2'd1; #1;
    chk(statTag, busRdData, {7'd0, mFlag});
  endtask

  task automatic setDbg(bit b);
    dbgFreeze = b; mDbg = b;
    @(negedge clk);
  endtask

  task automatic setStop(bit b);
    stopMode = b; mStop = b;
    if (b) mCnt = 0;
    @(negedge clk);
  endtask

  // one reference tick; collide = service write on the clock the tick lands
  task automatic tick(int hold, bit collide);
    bit    expReq;
    string tag;
    refTick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (collide) begin
      busWrEn = 1'b1; busAddr = 2'd1; busWrData = 8'($urandom);
    end
    @(negedge clk);
    busWrEn = 1'b0;
    expReq = 0;
    if (collide) begin
      tag = "R11 clear beats tick"; mCnt = 0;
    end else if (mStop) begin
      tag = "R9 stop holds zero"; mCnt = 0;
    end else if (mDbg) begin
      tag = "R8 freeze holds";
    end else if (!mEn) begin
      tag = "R7 disabled";
    end else begin
      tag = "R2 R3 timeout count";
      if (mCnt >= lastOf(mLong)) begin
        expReq = 1; mCnt = 0; mFlag = 1;
      end else begin
        mCnt++;
      end
    end
    chk(tag, rstReq, expReq);
    @(negedge clk);
    chk("R10 single pulse", rstReq, 0);
    repeat (hold) @(negedge clk);
    refTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));

    // R1 reset state
    doReset();
    chk("R1 no request", rstReq, 0);
    readChk("R1 option defaults", "R1 status clear");

    // R2 long default: 256th tick expires
    for (int i = 0; i < 256; i++) tick(0, 0);
    readChk("R5 options", "R10 flag set");

    // R2 short, R4 service
    doReset();
    writeOpt(8'h01);
    for (int i = 0; i < 31; i++) tick(0, 0);
    writeSvc(8'hFF);
    readChk("R5 options", "R4 status unchanged");
    for (int i = 0; i < 32; i++) tick(0, 0);
    writeSvc(8'h00);
    readChk("R5 options", "R4 flag kept after service");

    // R5 later write ignored and does not clear
    for (int i = 0; i < 10; i++) tick(0, 0);
    writeOpt(8'h02);
    readChk("R5 locked options", "R10 flag sticky");
    for (int i = 0; i < 22; i++) tick(0, 0);

    // R6 first write clears the count
    doReset();
    for (int i = 0; i < 20; i++) tick(0, 0);
    writeOpt(8'h01);
    for (int i = 0; i < 32; i++) tick(0, 0);

    // R7 disabled
    doReset();
    writeOpt(8'h00);
    for (int i = 0; i < 40; i++) tick(0, 0);
    readChk("R7 options off", "R7 no flag");

    // R3 long-held ticks
    doReset();
    writeOpt(8'h01);
    for (int i = 0; i < 32; i++) tick(12, 0);

    // R11 directed collision right before expiry
    for (int i = 0; i < 31; i++) tick(0, 0);
    tick(0, 1);
    for (int i = 0; i < 32; i++) tick(0, 0);

    // random phases
    for (int p = 0; p < 6; p++) begin
      doReset();
      for (int op = 0; op < 450; op++) begin
        int r;
        r = int'($urandom % 100);
        if ((p % 2 == 1) && r >= 60 && r < 68) r = 0;
        if (r < 60)      tick(int'($urandom % 6), 0);
        else if (r < 66) tick(0, 1);
        else if (r < 68) writeSvc(8'($urandom));
        else if (r < 72) begin
          logic [7:0] d;
          d = 8'($urandom);
          if (($urandom % 4) != 0) d[0] = 1'b1;
          writeOpt(d);
        end
        else if (r < 77) setDbg(!mDbg);
        else if (r < 81) setStop(!mStop);
        else             readChk("R5 options readback", "R10 flag readback");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule